// File: doc/BRIEF.md
# SPI Register and FIFO Front End

This block is the software-facing side of an SPI controller. A processor reaches it over a simple bus with single-cycle reads and writes. Through that bus it sets the enable, clock shaping, frame shaping and word-size settings that drive the serial engine. It pushes outgoing words into an eight-entry transmit queue and pops incoming words from an eight-entry receive queue. Both queues sit behind one shared data address.

The serial bit engine is outside this block. It takes words from the transmit queue with a pop handshake and delivers received words with a push strobe. The block watches the receive queue and raises a completion flag when a programmed fill level is reached. It raises an overrun flag when a word arrives with no room left. A single interrupt line reports each flag whose enable bit is set. Software reads the flags and writes ones at the same address to clear them.

Top module: `spi_regfront`

## Requirements
- R1: After reset every register reads 0, both queues are empty, `txValid` and `irq` are 0, and all configuration outputs are 0.
- R2: Configuration registers read back only their writable bits: word address 0x00 bit 0 (enable, drives `cfgEnable`); 0x04 bits 14:12 and 7:0 (clock shaping, `cfgClock`); 0x08 bits 13:0 (transmit word size, `cfgTxWords`); 0x0C bits 5:0 (receive word size, `cfgRxWords`); 0x10 bits 15:14 (frame shaping, `cfgFrame` = {bit15, bit14}); 0x18 bits 3 and 0 (interrupt enables). All other bits read 0.
- R3: A bus write to 0x24 appends the word to the 8-deep, 32-bit transmit queue. The engine receives the words in write order through `txPop`/`txWord`, with `txValid` high while the queue holds a word. A write to a full transmit queue is discarded.
- R4: An engine `rxPush` appends `rxWord` to the receive queue. A bus read of 0x24 returns and removes the oldest word, and returns 0 when the queue is empty. Address 0x14 bit 0 reads 1 exactly while the receive queue is not empty.
- R5: At 0x20, bits 11:8 (transmit level) and 3:0 (receive level) read back. Writing 1 to bit 12 or bit 4 empties the transmit or receive queue, so that the queue is empty in the next cycle. These two bits always read 0. A flush takes precedence over a push or pop in the same cycle.
- R6: The receive-complete flag (0x1C bit 3) is set when an engine push raises the receive count to equal a nonzero receive level. Bit 9 of 0x1C reads 1 while the receive level is nonzero and the count is at or above it.
- R7: An engine push into a full receive queue, with no pop or flush in that cycle, sets the overrun flag (0x1C bit 0) and discards the word. The queue contents stay unchanged.
- R8: The transmit-complete flag (0x1C bit 4) is set when an engine pop removes the last transmit word.
- R9: Writing 1 to bit 4, 3 or 0 of 0x1C clears the matching flag, and writing 0 leaves it alone. If a flag is set and cleared in the same cycle, it stays set.
- R10: `irq` is 1 exactly when (receive-complete AND enable bit 3) or (overrun AND enable bit 0).
- R11: Addresses above 0x24 or with nonzero bits 1:0 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| txPop | input | 1 | Engine takes the head transmit word |
| txValid | output | 1 | Transmit queue not empty |
| txWord | output | 32 | Head transmit word |
| rxPush | input | 1 | Engine delivers a received word |
| rxWord | input | 32 | Received word |
| cfgEnable | output | 1 | Controller enable |
| cfgClock | output | 15 | Clock shaping bits |
| cfgFrame | output | 2 | Frame polarity and start timing |
| cfgTxWords | output | 14 | Transmit word-size field |
| cfgRxWords | output | 6 | Receive word-size field |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties: the queue count never exceeds the depth, a flush leaves the queue empty, an overflowing push both sets the overrun flag and leaves the count at full, a completion event survives a simultaneous clear, and a clear without an event drops the flag. The directed scenarios show what only sequences can show. These are the first-in-first-out order on both queues, the exact push that reaches the receive level, the word discarded on overrun, the masking of register bits, the handling of unmapped addresses, and the gating of the interrupt line by the enables.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  typedef enum logic [3:0] {
    IDX_EN    = 4'd0,
    IDX_CLK   = 4'd1,
    IDX_TXWS  = 4'd2,
    IDX_RXWS  = 4'd3,
    IDX_FRAME = 4'd4,
    IDX_STAT  = 4'd5,
    IDX_IE    = 4'd6,
    IDX_IS    = 4'd7,
    IDX_FCTL  = 4'd8,
    IDX_DATA  = 4'd9,
    IDX_NONE  = 4'd15
  } regIdx_e;

  typedef struct packed {
    logic wrEn;
    logic wrClk;
    logic wrTxWs;
    logic wrRxWs;
    logic wrFrame;
    logic wrIe;
    logic wrIc;
    logic wrFctl;
    logic wrData;
    logic rdPop;
  } regStrobe_t;

  localparam int NUM_REGS   = 10;
  localparam int FC_TXFLUSH = 12;
  localparam int FC_RXFLUSH = 4;
  localparam int IS_RDY     = 9;
  localparam int IS_TC      = 4;
  localparam int IS_RC      = 3;
  localparam int IS_OR      = 0;

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             pushOk,
  output logic             popOk
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign popOk  = pop && !flush && (count != '0);
  assign pushOk = push && !flush && ((count != CW'(DEPTH)) || popOk);
  assign head   = (count == '0) ? '0 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0)); // R5

endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl import spi_rf_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output regIdx_e           rdIdx
);
  logic wr;

  always_comb begin
    rdIdx = IDX_NONE;
    if ((busAddr[1:0] == 2'b00) &&
        (busAddr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS)))
      rdIdx = regIdx_e'(busAddr[5:2]);
  end

  assign wr = busSel && busWrite;

  always_comb begin
    strobe = '0;
    if (wr) begin
      unique case (rdIdx)
        IDX_EN:    strobe.wrEn    = 1'b1;
        IDX_CLK:   strobe.wrClk   = 1'b1;
        IDX_TXWS:  strobe.wrTxWs  = 1'b1;
        IDX_RXWS:  strobe.wrRxWs  = 1'b1;
        IDX_FRAME: strobe.wrFrame = 1'b1;
        IDX_IE:    strobe.wrIe    = 1'b1;
        IDX_IS:    strobe.wrIc    = 1'b1;
        IDX_FCTL:  strobe.wrFctl  = 1'b1;
        IDX_DATA:  strobe.wrData  = 1'b1;
        default:   ;
      endcase
    end
    strobe.rdPop = busSel && !busWrite && (rdIdx == IDX_DATA);
  end

endmodule

// File: rtl/spi_rf_datapath.sv
module spi_rf_datapath import spi_rf_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strobe,
  input  regIdx_e     rdIdx,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        txPop,
  output logic        txValid,
  output logic [31:0] txWord,
  input  logic        rxPush,
  input  logic [31:0] rxWord,
  output logic        cfgEnable,
  output logic [14:0] cfgClock,
  output logic [1:0]  cfgFrame,
  output logic [13:0] cfgTxWords,
  output logic [5:0]  cfgRxWords,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] txCount, rxCount;
  logic txPushOk, txPopOk, rxPushOk, rxPopOk;
  logic [31:0] rxHead;
  logic txFlush, rxFlush, rxFull;
  logic ieRc, ieOr, rcFlag, orFlag, tcFlag;
  logic rcSet, orSet, tcSet, rxReady;
  logic [3:0] txThr, rxThr;

  assign txFlush = strobe.wrFctl && busWdata[FC_TXFLUSH];
  assign rxFlush = strobe.wrFctl && busWdata[FC_RXFLUSH];

  spi_rf_fifo #(.DEPTH(DEPTH), .WIDTH(32)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.wrData), .pushData(busWdata),
    .pop(txPop), .flush(txFlush), .head(txWord), .count(txCount),
    .pushOk(txPushOk), .popOk(txPopOk));

  spi_rf_fifo #(.DEPTH(DEPTH), .WIDTH(32)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData(rxWord),
    .pop(strobe.rdPop), .flush(rxFlush), .head(rxHead), .count(rxCount),
    .pushOk(rxPushOk), .popOk(rxPopOk));

  assign txValid = (txCount != '0);
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign rcSet   = rxPushOk && !rxPopOk && ((int'(rxCount) + 1) == int'(rxThr));
  assign orSet   = rxPush && rxFull && !rxPopOk && !rxFlush;
  assign tcSet   = txPopOk && !txPushOk && (txCount == CW'(1));
  assign rxReady = (rxThr != 4'd0) && (int'(rxCount) >= int'(rxThr));
  assign irq     = (rcFlag && ieRc) || (orFlag && ieOr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable  <= 1'b0;
      cfgClock   <= '0;
      cfgFrame   <= '0;
      cfgTxWords <= '0;
      cfgRxWords <= '0;
      ieRc       <= 1'b0;
      ieOr       <= 1'b0;
      txThr      <= '0;
      rxThr      <= '0;
      rcFlag     <= 1'b0;
      orFlag     <= 1'b0;
      tcFlag     <= 1'b0;
    end else begin
      if (strobe.wrEn)    cfgEnable  <= busWdata[0];
      if (strobe.wrClk)   cfgClock   <= {busWdata[14:12], 4'b0, busWdata[7:0]};
      if (strobe.wrFrame) cfgFrame   <= busWdata[15:14];
      if (strobe.wrTxWs)  cfgTxWords <= busWdata[13:0];
      if (strobe.wrRxWs)  cfgRxWords <= busWdata[5:0];
      if (strobe.wrIe) begin
        ieRc <= busWdata[3];
        ieOr <= busWdata[0];
      end
      if (strobe.wrFctl) begin
        txThr <= busWdata[11:8];
        rxThr <= busWdata[3:0];
      end
      rcFlag <= rcSet || (rcFlag && !(strobe.wrIc && busWdata[IS_RC]));
      orFlag <= orSet || (orFlag && !(strobe.wrIc && busWdata[IS_OR]));
      tcFlag <= tcSet || (tcFlag && !(strobe.wrIc && busWdata[IS_TC]));
    end
  end

  always_comb begin
    unique case (rdIdx)
      IDX_EN:    busRdata = {31'b0, cfgEnable};
      IDX_CLK:   busRdata = {17'b0, cfgClock};
      IDX_TXWS:  busRdata = {18'b0, cfgTxWords};
      IDX_RXWS:  busRdata = {26'b0, cfgRxWords};
      IDX_FRAME: busRdata = {16'b0, cfgFrame, 14'b0};
      IDX_STAT:  busRdata = {31'b0, (rxCount != '0)};
      IDX_IE:    busRdata = {28'b0, ieRc, 2'b0, ieOr};
      IDX_IS:    busRdata = {22'b0, rxReady, 4'b0, tcFlag, rcFlag, 2'b0, orFlag};
      IDX_FCTL:  busRdata = {20'b0, txThr, 4'b0, rxThr};
      IDX_DATA:  busRdata = rxHead;
      default:   busRdata = '0;
    endcase
  end

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && (rxCount == CW'(DEPTH)) && !strobe.rdPop && !rxFlush) |=> orFlag); // R7
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && (rxCount == CW'(DEPTH)) && !strobe.rdPop && !rxFlush) |=> (rxCount == CW'(DEPTH))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rxPushOk && !rxPopOk && ((int'(rxCount) + 1) == int'(rxThr))) |=> rcFlag); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrIc && busWdata[IS_OR] && !rxPush) |=> !orFlag); // R9

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront import spi_rf_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              txPop,
  output logic              txValid,
  output logic [31:0]       txWord,
  input  logic              rxPush,
  input  logic [31:0]       rxWord,
  output logic              cfgEnable,
  output logic [14:0]       cfgClock,
  output logic [1:0]        cfgFrame,
  output logic [13:0]       cfgTxWords,
  output logic [5:0]        cfgRxWords,
  output logic              irq
);
  regStrobe_t strobe;
  regIdx_e    rdIdx;

  spi_rf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strobe(strobe), .rdIdx(rdIdx));

  spi_rf_datapath #(.DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx),
    .busWdata(busWdata), .busRdata(busRdata),
    .txPop(txPop), .txValid(txValid), .txWord(txWord),
    .rxPush(rxPush), .rxWord(rxWord),
    .cfgEnable(cfgEnable), .cfgClock(cfgClock), .cfgFrame(cfgFrame),
    .cfgTxWords(cfgTxWords), .cfgRxWords(cfgRxWords), .irq(irq));

endmodule

// File: tb/sim_spi_regfront.sv
`timescale 1ns/1ps
module sim_spi_regfront;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txPop = 1'b0, txValid;
  logic [31:0] txWord;
  logic        rxPush = 1'b0;
  logic [31:0] rxWord = '0;
  logic        cfgEnable, irq;
  logic [14:0] cfgClock;
  logic [1:0]  cfgFrame;
  logic [13:0] cfgTxWords;
  logic [5:0]  cfgRxWords;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_regfront u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txPop(txPop), .txValid(txValid), .txWord(txWord),
    .rxPush(rxPush), .rxWord(rxWord), .cfgEnable(cfgEnable),
    .cfgClock(cfgClock), .cfgFrame(cfgFrame), .cfgTxWords(cfgTxWords),
    .cfgRxWords(cfgRxWords), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    chk(req, d, exp);
  endtask

  task automatic engPush(input logic [31:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxWord = d;
    @(posedge clk); #1;
    rxPush = 1'b0;
  endtask

  task automatic engPop(output logic v, output logic [31:0] d);
    @(negedge clk);
    txPop = 1'b1;
    #1 v = txValid; d = txWord;
    @(posedge clk); #1;
    txPop = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 9; a++) rdChk("R1", 6'(a * 4), 32'h0);
    chk("R1", {31'b0, irq}, 0);
    chk("R1", {31'b0, txValid}, 0);
    chk("R1", {16'b0, cfgEnable, cfgClock}, 0);
    chk("R1", {10'b0, cfgFrame, cfgTxWords, cfgRxWords}, 0);
  endtask

  task automatic t_config;
    busWr(6'h00, 32'hFFFF_FFFF); rdChk("R2", 6'h00, 32'h1);
    chk("R2 enable out", {31'b0, cfgEnable}, 1);
    busWr(6'h04, 32'hFFFF_FFFF); rdChk("R2", 6'h04, 32'h70FF);
    busWr(6'h04, 32'h0000_1234); rdChk("R2", 6'h04, 32'h1034);
    chk("R2 clock out", {17'b0, cfgClock}, 32'h1034);
    busWr(6'h08, 32'hFFFF_FFFF); rdChk("R2", 6'h08, 32'h3FFF);
    chk("R2 txws out", {18'b0, cfgTxWords}, 32'h3FFF);
    busWr(6'h0C, 32'hFFFF_FFFF); rdChk("R2", 6'h0C, 32'h3F);
    chk("R2 rxws out", {26'b0, cfgRxWords}, 32'h3F);
    busWr(6'h10, 32'hFFFF_FFFF); rdChk("R2", 6'h10, 32'hC000);
    busWr(6'h10, 32'h0000_4000);
    chk("R2 frame out", {30'b0, cfgFrame}, 32'h1);
    busWr(6'h18, 32'hFFFF_FFFF); rdChk("R2", 6'h18, 32'h9);
    chk("R10 no flag no irq", {31'b0, irq}, 0);
    busWr(6'h18, 32'h0);
  endtask

  task automatic t_unmapped;
    busWr(6'h28, 32'hFFFF_FFFF); rdChk("R11", 6'h28, 32'h0);
    busWr(6'h01, 32'h0);          rdChk("R11", 6'h00, 32'h1);
    rdChk("R11", 6'h05, 32'h0);
    busWr(6'h3C, 32'hFFFF_FFFF); rdChk("R11", 6'h18, 32'h0);
  endtask

  task automatic t_tx;
    logic v; logic [31:0] d;
    for (int i = 0; i < 9; i++) busWr(6'h24, 32'hC0DE_0000 + i);
    chk("R3 valid", {31'b0, txValid}, 1);
    for (int i = 0; i < 8; i++) begin
      engPop(v, d);
      chk("R3 order", d, 32'hC0DE_0000 + i);
    end
    chk("R3 drop ninth", {31'b0, txValid}, 0);
    engPop(v, d);
    chk("R3 empty pop", {31'b0, v}, 0);
    rdChk("R8", 6'h1C, 32'h10);
    busWr(6'h1C, 32'h0);  rdChk("R9 zero keeps", 6'h1C, 32'h10);
    busWr(6'h1C, 32'h10); rdChk("R9", 6'h1C, 32'h0);
  endtask

  task automatic t_rx;
    engPush(32'h1111_1111); engPush(32'h2222_2222); engPush(32'h3333_3333);
    rdChk("R4 status", 6'h14, 32'h1);
    rdChk("R4", 6'h24, 32'h1111_1111);
    rdChk("R4", 6'h24, 32'h2222_2222);
    rdChk("R4", 6'h24, 32'h3333_3333);
    rdChk("R4 status", 6'h14, 32'h0);
    rdChk("R4 empty", 6'h24, 32'h0);
  endtask

  task automatic t_level;
    busWr(6'h20, 32'h0000_0503); rdChk("R5 levels", 6'h20, 32'h503);
    engPush(32'hA); engPush(32'hB);
    rdChk("R6 below", 6'h1C, 32'h0);
    engPush(32'hC);
    rdChk("R6 reached", 6'h1C, 32'h208);
    chk("R10 disabled", {31'b0, irq}, 0);
    busWr(6'h18, 32'h8);
    chk("R10 enabled", {31'b0, irq}, 1);
    busWr(6'h18, 32'h1);
    chk("R10 other enable", {31'b0, irq}, 0);
    busWr(6'h18, 32'h8);
    busWr(6'h1C, 32'h8);
    chk("R10 cleared", {31'b0, irq}, 0);
    rdChk("R9 ready stays", 6'h1C, 32'h200);
    busWr(6'h18, 32'h0);
    for (int i = 0; i < 3; i++) rdChk("R4 drain", 6'h24, 32'hA + i);
  endtask

  task automatic t_overrun;
    busWr(6'h20, 32'h0);
    busWr(6'h1C, 32'h19);
    for (int i = 0; i < 8; i++) engPush(32'hA0 + i);
    rdChk("R7 not yet", 6'h1C, 32'h0);
    engPush(32'hBAD);
    rdChk("R7 set", 6'h1C, 32'h1);
    busWr(6'h18, 32'h1);
    chk("R10 overrun irq", {31'b0, irq}, 1);
    busWr(6'h1C, 32'h1);
    chk("R9 overrun clear", {31'b0, irq}, 0);
    busWr(6'h18, 32'h0);
    for (int i = 0; i < 8; i++) rdChk("R7 kept", 6'h24, 32'hA0 + i);
    rdChk("R7 dropped", 6'h14, 32'h0);
  endtask

  task automatic t_flush;
    engPush(32'h55); engPush(32'h66);
    busWr(6'h24, 32'h77); busWr(6'h24, 32'h88);
    busWr(6'h20, 32'h0000_1013);
    rdChk("R5 selfclear", 6'h20, 32'h3);
    rdChk("R5 rx empty", 6'h14, 32'h0);
    chk("R5 tx empty", {31'b0, txValid}, 0);
    rdChk("R5 empty read", 6'h24, 32'h0);
  endtask

  task automatic t_setwins;
    busWr(6'h20, 32'h1);
    @(negedge clk);
    rxPush = 1'b1; rxWord = 32'h99;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 6'h1C; busWdata = 32'h8;
    @(posedge clk); #1;
    rxPush = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    rdChk("R9 set wins", 6'h1C, 32'h208);
    rdChk("R4", 6'h24, 32'h99);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset;
    t_config;
    t_unmapped;
    t_tx;
    t_rx;
    t_level;
    t_overrun;
    t_flush;
    t_setwins;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule